// File: doc/BRIEF.md
# Dynamic range gain scaler

This block adjusts a per-block dynamic range gain word, decoded from an audio bitstream, before that gain is turned into a linear factor and applied to the samples. The gain arrives as a signed 16-bit log-domain (dB) fixed-point value. A host chooses how much of the coded compression or expansion is honoured. It does this through two 8-bit fractional scale registers: one for gains that cut (negative dB) and one for gains that boost (positive dB).

For each incoming gain word the block picks a register by the sign of the gain. It multiplies the gain by the fraction that register encodes, rounds the result back to the input format and presents it one cycle later with a valid strobe. A code of 0x00 removes the coded gain entirely. A code of 0xFF keeps it unchanged. Both registers can be read back at any time.

Top module: `dyn_gain_scaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, both scale registers become 0xFF, `gain_out_valid` becomes 0 and `gain_out` becomes 0.
- R2: A write (`cfg_wr_en`=1) loads `cfg_wr_data` into the cut register when `cfg_wr_sel`=0 and into the boost register when `cfg_wr_sel`=1. `cfg_rd_data` shows the cut register when `cfg_rd_sel`=0 and the boost register when `cfg_rd_sel`=1. Without a write, both registers hold their value.
- R3: A gain word with bit 15 set (negative) is scaled by the cut register. A zero or positive word is scaled by the boost register.
- R4: For a code c from 0x01 to 0xFF, the output is the gain multiplied by (c+1)/256 and rounded to the nearest integer, with exact halves rounded away from zero.
- R5: A selected code of 0x00 forces the output gain to 0.
- R6: A selected code of 0xFF returns the input gain unchanged, including -32768.
- R7: An input gain of 0 gives an output gain of 0 whatever the register values are.
- R8: `gain_out_valid` is high in exactly the cycle after each cycle with `gain_in_valid` high, and the result appears with it. While no result is produced, `gain_out` holds the previous result.
- R9: A register write made in the same cycle as an input word does not affect that word. It takes effect from the next word onward, and it does not change a result already presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Scale register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 cut register, 1 boost register |
| cfg_wr_data | input | 8 | Scale code to write |
| cfg_rd_sel | input | 1 | Readback source: 0 cut register, 1 boost register |
| cfg_rd_data | output | 8 | Selected scale register value |
| gain_in_valid | input | 1 | Input gain word valid |
| gain_in | input | 16 | Signed log-domain coded gain |
| gain_out_valid | output | 1 | Scaled gain valid, one cycle after input |
| gain_out | output | 16 | Signed scaled log-domain gain |

## Verification
The assertions assume that every input carries a known value at each clock edge after reset. They also assume that any 16-bit pattern may appear on `gain_in`, including -32768, and that register writes may coincide with input words. The stimulus drives all inputs from zero at time zero and changes them only between edges. It covers both register codes at the extremes (0x00, 0x01, 0x7F, 0xFE, 0xFF), rounding ties of both signs and the most negative gain. It deliberately collides writes with input words, so the write-ordering rule and the sign-based register choice are exercised under the same conditions the assertions rely on.

// File: rtl/dgs_pkg.sv
// Package: shared constants and types for the dynamic range gain scaler.
// Assumes: the scale code is the fraction numerator minus one over 2^CODE_W.
package dgs_pkg;

    // Register bank index: which scale register a write or read addresses.
    typedef enum logic {
        SCALE_CUT   = 1'b0,
        SCALE_BOOST = 1'b1
    } scale_sel_e;

    localparam int NUM_SCALE_REGS = 2;

endpackage

// File: rtl/dgs_scale_regs.sv
// Module: dgs_scale_regs
// Holds the cut and boost scale codes, writable and readable by the host.
// Assumes: a single write port; a write is visible from the next cycle on.
module dgs_scale_regs
    import dgs_pkg::*;
#(
    parameter int                CODE_W     = 8,
    parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] cut_code,
    output logic [CODE_W-1:0] boost_code
);

    logic [CODE_W-1:0] code_q [NUM_SCALE_REGS];

    // One register per scale factor, each loaded only when addressed.
    for (genvar i = 0; i < NUM_SCALE_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[i] <= RESET_CODE;
            end else if (wr_en && (wr_sel == 1'(i))) begin
                code_q[i] <= wr_data;
            end
        end
    end

    // Readback multiplexer and per-sign code outputs.
    always_comb begin
        rd_data    = code_q[rd_sel];
        cut_code   = code_q[SCALE_CUT];
        boost_code = code_q[SCALE_BOOST];
    end

    // R2: a write lands in the addressed register.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> code_q[$past(wr_sel)] == $past(wr_data));

    // R2: without a write both registers keep their value.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cut_code) && $stable(boost_code));

endmodule

// File: rtl/dgs_scale_pipe.sv
// Module: dgs_scale_pipe
// Multiplies a signed gain by (code+1)/2^CODE_W, rounds half away from zero,
// forces zero for code 0, and registers the result with its valid strobe.
// Assumes: the code is stable in the cycle the gain word is presented.
module dgs_scale_pipe #(
    parameter int GAIN_W = 16,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [GAIN_W-1:0] in_gain,
    input  logic [CODE_W-1:0]        code,
    output logic                     out_valid,
    output logic signed [GAIN_W-1:0] out_gain
);

    localparam int FRAC_W = CODE_W + 2;
    localparam int PROD_W = GAIN_W + FRAC_W;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (CODE_W - 1);

    logic signed [FRAC_W-1:0] factor;
    logic signed [PROD_W-1:0] prod;
    logic                     neg;
    logic [PROD_W-1:0]        mag;
    logic [PROD_W-1:0]        sum;
    logic [PROD_W-1:0]        rounded;
    logic [GAIN_W-1:0]        res_mag;
    logic signed [GAIN_W-1:0] result;

    // Signed multiply by the fraction numerator, then sign-magnitude rounding.
    always_comb begin
        factor  = $signed({2'b00, code} + FRAC_W'(1));
        prod    = PROD_W'(in_gain) * PROD_W'(factor);
        neg     = prod[PROD_W-1];
        mag     = neg ? -prod : prod;
        sum     = mag + HALF;
        rounded = sum >> CODE_W;
        res_mag = rounded[GAIN_W-1:0];
        if (code == '0) begin
            result = '0;
        end else if (neg) begin
            result = -$signed(res_mag);
        end else begin
            result = $signed(res_mag);
        end
    end

    // Output register: result captured only with a valid input word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_gain  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_gain <= result;
            end
        end
    end

    // R4: the rounded magnitude never exceeds the output word.
    p_mag_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> rounded[PROD_W-1:GAIN_W] == '0);

    // R8: a valid input yields a valid output on the next cycle.
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: no input, no output, and the last result is held.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_gain));

    // R5: a zero code removes the gain.
    p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && code == '0 |=> out_gain == '0);

endmodule

// File: rtl/dyn_gain_scaler.sv
// Module: dyn_gain_scaler (top)
// Scales a coded dynamic range gain by a host fraction chosen by its sign:
// the cut register for negative gains, the boost register otherwise.
// Assumes: one gain word per valid cycle; one cycle latency to the output.
module dyn_gain_scaler #(
    parameter int GAIN_W = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [CODE_W-1:0] cfg_wr_data,
    input  logic              cfg_rd_sel,
    output logic [CODE_W-1:0] cfg_rd_data,
    input  logic              gain_in_valid,
    input  logic [GAIN_W-1:0] gain_in,
    output logic              gain_out_valid,
    output logic [GAIN_W-1:0] gain_out
);

    localparam logic [CODE_W-1:0] UNITY_CODE = '1;

    logic [CODE_W-1:0]        cut_code;
    logic [CODE_W-1:0]        boost_code;
    logic [CODE_W-1:0]        code_sel;
    logic signed [GAIN_W-1:0] scaled;

    dgs_scale_regs #(
        .CODE_W     (CODE_W),
        .RESET_CODE (UNITY_CODE)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .rd_sel     (cfg_rd_sel),
        .rd_data    (cfg_rd_data),
        .cut_code   (cut_code),
        .boost_code (boost_code)
    );

    // Sign of the coded gain picks the cut or boost code.
    always_comb begin
        code_sel = gain_in[GAIN_W-1] ? cut_code : boost_code;
    end

    dgs_scale_pipe #(
        .GAIN_W (GAIN_W),
        .CODE_W (CODE_W)
    ) pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (gain_in_valid),
        .in_gain   ($signed(gain_in)),
        .code      (code_sel),
        .out_valid (gain_out_valid),
        .out_gain  (scaled)
    );

    // Output port driven from the registered result.
    always_comb begin
        gain_out = scaled;
    end

    // R7: zero dB passes through as zero.
    p_zero_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_in_valid && gain_in == '0 |=> gain_out == '0);

    // R3: a boost never turns into a cut.
    p_sign_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gain_in_valid && !gain_in[GAIN_W-1] |=> !gain_out[GAIN_W-1]);

    // R6: full-scale code leaves the gain unchanged.
    p_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_in_valid && code_sel == UNITY_CODE |=> gain_out == $past(gain_in));

endmodule

// File: tb/dyn_gain_scaler_tb_top.sv
// Bench: behavioural reference model compared with the design on every clock.
module dyn_gain_scaler_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic        cfg_rd_sel = 1'b0;
    logic [7:0]  cfg_rd_data;
    logic        gain_in_valid = 1'b0;
    logic [15:0] gain_in = 16'h0000;
    logic        gain_out_valid;
    logic [15:0] gain_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dyn_gain_scaler dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_sel     (cfg_wr_sel),
        .cfg_wr_data    (cfg_wr_data),
        .cfg_rd_sel     (cfg_rd_sel),
        .cfg_rd_data    (cfg_rd_data),
        .gain_in_valid  (gain_in_valid),
        .gain_in        (gain_in),
        .gain_out_valid (gain_out_valid),
        .gain_out       (gain_out)
    );

    // Reference arithmetic taken from R4..R7.
    function automatic int ref_scale(int g, int c);
        int p, m, r;
        if (c == 0) return 0;
        p = g * (c + 1);
        m = (p < 0) ? -p : p;
        r = (m + 128) / 256;
        return (p < 0) ? -r : r;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    int    m_cut = 255, m_boost = 255;
    int    e_valid = 0, e_gain = 0;
    string e_tag = "R1";

    // Model update at each edge, then comparison 2 ns later.
    always @(posedge clk) begin
        int g, c;
        if (!rst_n) begin
            m_cut = 255; m_boost = 255; e_valid = 0; e_gain = 0; e_tag = "R1";
        end else begin
            if (gain_in_valid) begin
                g = $signed(gain_in);
                c = (g < 0) ? m_cut : m_boost;
                e_gain = ref_scale(g, c);
                e_valid = 1;
                if (cfg_wr_en)   e_tag = "R9";
                else if (g == 0) e_tag = "R7";
                else if (c == 0) e_tag = "R5";
                else if (c == 255) e_tag = "R6";
                else if (g < 0)  e_tag = "R3";
                else             e_tag = "R4";
            end else begin
                e_valid = 0;
                e_tag = "R8";
            end
            if (cfg_wr_en) begin
                if (cfg_wr_sel) m_boost = cfg_wr_data;
                else            m_cut = cfg_wr_data;
            end
        end
        #2;
        if (!done) begin
            check("R8 valid", int'(gain_out_valid), e_valid);
            check(e_tag, int'($signed(gain_out)), e_gain);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr_en = 0; gain_in_valid = 0;
        end
    endtask

    task automatic put(int g);
        @(negedge clk);
        cfg_wr_en = 0; gain_in_valid = 1; gain_in = 16'(g);
    endtask

    task automatic wr(bit sel, int v);
        @(negedge clk);
        gain_in_valid = 0;
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = 8'(v);
    endtask

    task automatic wr_put(bit sel, int v, int g);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = 8'(v);
        gain_in_valid = 1; gain_in = 16'(g);
    endtask

    task automatic rd_check(bit sel, int exp, string tag);
        @(negedge clk);
        cfg_wr_en = 0; gain_in_valid = 0; cfg_rd_sel = sel;
        #1;
        check(tag, int'(cfg_rd_data), exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", int'(gain_out_valid), 0);
        check("R1 gain", int'(gain_out), 0);
        @(negedge clk);
        rst_n = 1;
        rd_check(0, 255, "R1 cut reset");
        rd_check(1, 255, "R1 boost reset");
        // Unity defaults (R6), including extremes.
        put(-32768); put(32767); put(-1); put(1); put(0);
        idle(2);
        // Register programming and readback (R2).
        wr(0, 8'h00); wr(1, 8'h7F);
        rd_check(0, 8'h00, "R2 cut readback");
        rd_check(1, 8'h7F, "R2 boost readback");
        // Sign selection (R3), zero code (R5), ties (R4).
        put(-1000); put(1); put(3); put(5); put(0); put(-32768);
        wr(0, 8'h7F);
        put(-1); put(-3); put(-32768); put(32767);
        wr(0, 8'h01); wr(1, 8'hFE);
        put(-300); put(300); put(-64); put(64); put(32767);
        idle(1);
        // Write colliding with a word (R9).
        wr(0, 8'hFF);
        wr_put(0, 8'h00, -5000);
        put(-5000);
        wr_put(1, 8'h00, 4000);
        idle(2);
        rd_check(0, 8'h00, "R9 cut after collision");
        rd_check(1, 8'h00, "R9 boost after collision");
        // Mixed random traffic.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_wr_en = ($urandom_range(0, 7) == 0);
            cfg_wr_sel = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 4))
                0: cfg_wr_data = 8'h00;
                1: cfg_wr_data = 8'hFF;
                default: cfg_wr_data = 8'($urandom_range(0, 255));
            endcase
            gain_in_valid = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 5))
                0: gain_in = 16'h8000;
                1: gain_in = 16'h0000;
                2: gain_in = 16'($urandom_range(0, 600)) - 16'd300;
                default: gain_in = 16'($urandom_range(0, 65535));
            endcase
        end
        idle(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule